// File: doc/BRIEF.md
# Fully Associative Page Translation Cache

This block stores a handful of recent page translations. Each slot pairs a 20-bit linear page number with a 20-bit physical frame number and has a valid flag. Every valid slot is compared against the requested page number in parallel. The hit flag and the frame come out combinationally, in the same cycle as the request. A fill port writes a new translation. The slot it uses is chosen in this order: a slot that already holds that page, then the lowest empty slot, then the least recently used slot.

Two invalidation inputs keep the contents coherent with the page tables. A flush clears every slot, and is used when the page-table base changes. A single-page invalidate clears only the slot whose page number matches. Both invalidations act before a fill given in the same cycle, so that fill always sees the cleaned contents.

A small occupancy state machine chooses how the victim is picked. It has three states. ST_EMPTY means no slot is valid, and the victim is slot 0. ST_PARTIAL means some slots are free, and the victim is the lowest free slot. ST_FULL means every slot is valid, and the victim is the least recently used slot. The transitions are as follows. A fill takes EMPTY to PARTIAL, or to FULL when there is one slot. A fill into the last free slot takes PARTIAL to FULL. A single-page invalidate that hits takes FULL to PARTIAL. A flush, or the removal of the last valid slot, takes any state to ST_EMPTY.

Top module: `xlate_cache`

## Requirements
- R1: After reset every slot is invalid, so a lookup of page 0 (or of any page) returns lk_hit=0 and lk_frame=0.
- R2: Lookup is combinational. In the same cycle that lk_page is presented, lk_hit=1 and lk_frame equals the stored frame if a valid slot holds that page. Otherwise lk_hit=0 and lk_frame=0.
- R3: A fill of a page that is not present goes into the lowest-numbered invalid slot. Successive fills after reset or after a flush therefore occupy slots 0, 1, 2, 3 in turn, and each filled page can be looked up from the next cycle on.
- R4: When every slot is valid, a fill of a new page replaces the least recently used slot. Both a fill and a lookup hit mark their slot as most recently used.
- R5: A fill of a page that is already present overwrites that slot's frame in place. No second copy is created and no other slot is evicted.
- R6: flush_all clears every slot at the next edge. If fill_en is asserted in the same cycle, the flush is applied first, and afterwards only the filled page is present.
- R7: inv_en clears only the valid slot whose page equals inv_page. Other slots are untouched, and an inv_page that matches nothing changes nothing.
- R8: A lookup hit does not update recency in a cycle that also has fill_en or flush_all asserted.
- R9: When inv_en and fill_en are asserted together, the invalidation is applied first. The fill then sees the freed slot as empty and may land there instead of evicting another entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| lk_page | input | 20 | Page number to translate |
| lk_hit | output | 1 | A valid slot holds lk_page |
| lk_frame | output | 20 | Frame of the matching slot, 0 on a miss |
| fill_en | input | 1 | Write a translation this cycle |
| fill_page | input | 20 | Page number to write |
| fill_frame | input | 20 | Frame number to write |
| flush_all | input | 1 | Invalidate every slot |
| inv_en | input | 1 | Invalidate the slot that holds inv_page |
| inv_page | input | 20 | Page number to invalidate |

## Verification
Lookup results are due in the same cycle as the key. The bench therefore drives its inputs on the falling edge and compares lk_hit and lk_frame one time unit later, before the next rising edge. Fills, flushes and invalidations take effect at that rising edge. A behavioural model, built from arrays and per-slot timestamps, applies the same update straight after each comparison, so the next cycle's lookup is checked against the updated contents. Eviction order and in-place updates have no output of their own. They are observed through later lookups that must hit or miss.

// File: rtl/xc_pkg.sv
package xc_pkg;
    typedef enum logic [1:0] {
        ST_EMPTY   = 2'd0,
        ST_PARTIAL = 2'd1,
        ST_FULL    = 2'd2
    } occ_e;
endpackage

// File: rtl/xc_match.sv
module xc_match #(
    parameter int N = 4,
    parameter int W = 20
) (
    input  logic [N-1:0]        valid,
    input  logic [N-1:0][W-1:0] keys,
    input  logic [W-1:0]        probe,
    output logic [N-1:0]        match
);
    genvar i;
    generate
        for (i = 0; i < N; i++) begin : g_cmp
            assign match[i] = valid[i] && (keys[i] == probe);
        end
    endgenerate
endmodule

// File: rtl/xc_lru.sv
module xc_lru #(
    parameter int N  = 4,
    parameter int IW = (N > 1) ? $clog2(N) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          touch_en,
    input  logic [IW-1:0] touch_idx,
    output logic [IW-1:0] lru_idx
);
    // rank 0 = most recent, rank N-1 = least recent; ranks stay a permutation
    logic [N-1:0][IW-1:0] rank_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < N; i++) rank_q[i] <= IW'(i);
        end else if (touch_en) begin
            for (int i = 0; i < N; i++) begin
                if (IW'(i) == touch_idx)
                    rank_q[i] <= '0;
                else if (rank_q[i] < rank_q[touch_idx])
                    rank_q[i] <= rank_q[i] + 1'b1;
            end
        end
    end

    always_comb begin
        lru_idx = '0;
        for (int i = 0; i < N; i++)
            if (rank_q[i] == IW'(N - 1)) lru_idx = IW'(i);
    end
endmodule

// File: rtl/xlate_cache.sv
module xlate_cache #(
    parameter int N = 4,
    parameter int W = 20
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] lk_page,
    output logic         lk_hit,
    output logic [W-1:0] lk_frame,
    input  logic         fill_en,
    input  logic [W-1:0] fill_page,
    input  logic [W-1:0] fill_frame,
    input  logic         flush_all,
    input  logic         inv_en,
    input  logic [W-1:0] inv_page
);
    import xc_pkg::*;

    localparam int IW = (N > 1) ? $clog2(N) : 1;

    logic [N-1:0]        ent_valid;
    logic [N-1:0][W-1:0] ent_key;
    logic [N-1:0][W-1:0] ent_frame;
    occ_e                st_q, st_d, mid_occ;

    logic [N-1:0]  lk_vec, inv_raw, inv_vec, fill_vec, valid_mid, valid_d;
    logic [IW-1:0] lk_idx, fill_idx, free_idx, lru_idx, victim, fill_tgt, touch_idx;
    logic          touch_en;

    // parallel tag compare: lookup, invalidate, fill (against cleaned state)
    xc_match #(.N(N), .W(W)) u_lk_match (
        .valid(ent_valid), .keys(ent_key), .probe(lk_page), .match(lk_vec)
    );
    xc_match #(.N(N), .W(W)) u_inv_match (
        .valid(ent_valid), .keys(ent_key), .probe(inv_page), .match(inv_raw)
    );
    xc_match #(.N(N), .W(W)) u_fill_match (
        .valid(valid_mid), .keys(ent_key), .probe(fill_page), .match(fill_vec)
    );

    assign inv_vec   = inv_en ? inv_raw : '0;
    assign valid_mid = flush_all ? '0 : (ent_valid & ~inv_vec);

    // lookup result
    always_comb begin
        lk_frame = '0;
        lk_idx   = '0;
        for (int i = 0; i < N; i++) begin
            if (lk_vec[i]) begin
                lk_frame = lk_frame | ent_frame[i];
                lk_idx   = IW'(i);
            end
        end
    end
    assign lk_hit = |lk_vec;

    // fill match index and lowest free slot
    always_comb begin
        fill_idx = '0;
        free_idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (fill_vec[i])   fill_idx = IW'(i);
            if (!valid_mid[i]) free_idx = IW'(i);
        end
    end

    xc_lru #(.N(N), .IW(IW)) u_lru (
        .clk(clk), .rst_n(rst_n), .touch_en(touch_en),
        .touch_idx(touch_idx), .lru_idx(lru_idx)
    );

    // occupancy after this cycle's invalidations
    always_comb begin
        mid_occ = st_q;
        unique case (st_q)
            ST_EMPTY:   mid_occ = ST_EMPTY;
            ST_PARTIAL: mid_occ = (|valid_mid) ? ST_PARTIAL : ST_EMPTY;
            ST_FULL:    mid_occ = (&valid_mid) ? ST_FULL :
                                  ((|valid_mid) ? ST_PARTIAL : ST_EMPTY);
            default:    mid_occ = ST_EMPTY;
        endcase
        if (flush_all) mid_occ = ST_EMPTY;
    end

    // output decode: victim per occupancy state
    always_comb begin
        victim = '0;
        unique case (mid_occ)
            ST_EMPTY:   victim = '0;
            ST_PARTIAL: victim = free_idx;
            ST_FULL:    victim = lru_idx;
            default:    victim = '0;
        endcase
    end

    assign fill_tgt  = (|fill_vec) ? fill_idx : victim;
    assign touch_en  = fill_en || (lk_hit && !flush_all);
    assign touch_idx = fill_en ? fill_tgt : lk_idx;

    always_comb begin
        valid_d = valid_mid;
        if (fill_en) valid_d[fill_tgt] = 1'b1;
    end

    // next occupancy state
    always_comb begin
        if (valid_d == '0)
            st_d = ST_EMPTY;
        else if (&valid_d)
            st_d = ST_FULL;
        else
            st_d = ST_PARTIAL;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= ST_EMPTY;
        else        st_q <= st_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ent_valid <= '0;
            ent_key   <= '0;
            ent_frame <= '0;
        end else begin
            ent_valid <= valid_d;
            if (fill_en) begin
                ent_key[fill_tgt]   <= fill_page;
                ent_frame[fill_tgt] <= fill_frame;
            end
        end
    end
endmodule

// File: rtl/xc_chk.sv
module xc_chk #(
    parameter int N = 4,
    parameter int W = 20
) (
    input logic                clk,
    input logic                rst_n,
    input logic                lk_hit,
    input logic [W-1:0]        lk_frame,
    input logic [N-1:0]        lk_vec,
    input logic [N-1:0]        ent_valid,
    input logic [N-1:0][W-1:0] ent_key,
    input logic                flush_all,
    input logic                fill_en,
    input logic [W-1:0]        fill_page,
    input logic                inv_en,
    input logic [W-1:0]        inv_page
);
    function automatic logic holds(input logic [N-1:0] v,
                                   input logic [N-1:0][W-1:0] k,
                                   input logic [W-1:0] pg);
        logic r;
        r = 1'b0;
        for (int i = 0; i < N; i++) if (v[i] && k[i] == pg) r = 1'b1;
        return r;
    endfunction

    p_hit_onehot_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(lk_vec));

    p_miss_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !lk_hit |-> lk_frame == '0);

    p_fill_present_r3: assert property (@(posedge clk) disable iff (!rst_n)
        fill_en |=> holds(ent_valid, ent_key, $past(fill_page)));

    p_flush_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
        flush_all && !fill_en |=> ent_valid == '0);

    p_flush_fill_r6: assert property (@(posedge clk) disable iff (!rst_n)
        flush_all && fill_en |=> $countones(ent_valid) == 1);

    p_inv_gone_r7: assert property (@(posedge clk) disable iff (!rst_n)
        inv_en && !(fill_en && fill_page == inv_page)
        |=> !holds(ent_valid, ent_key, $past(inv_page)));
endmodule

bind xlate_cache xc_chk #(.N(N), .W(W)) u_chk (
    .clk(clk), .rst_n(rst_n), .lk_hit(lk_hit), .lk_frame(lk_frame),
    .lk_vec(lk_vec), .ent_valid(ent_valid), .ent_key(ent_key),
    .flush_all(flush_all), .fill_en(fill_en), .fill_page(fill_page),
    .inv_en(inv_en), .inv_page(inv_page)
);

// File: tb/xlate_cache_test.sv
`timescale 1ns/1ps
module xlate_cache_test;
    localparam int N = 4;
    localparam int W = 20;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [W-1:0] lk_page = '0;
    logic         lk_hit;
    logic [W-1:0] lk_frame;
    logic         fill_en = 1'b0;
    logic [W-1:0] fill_page = '0, fill_frame = '0;
    logic         flush_all = 1'b0;
    logic         inv_en = 1'b0;
    logic [W-1:0] inv_page = '0;

    int total = 0;
    int bad = 0;
    bit done = 0;

    // reference model
    bit           m_v[N];
    logic [W-1:0] m_k[N];
    logic [W-1:0] m_f[N];
    int           m_t[N];
    int           now = 0;

    always #2 clk = ~clk;

    xlate_cache #(.N(N), .W(W)) uut (
        .clk(clk), .rst_n(rst_n), .lk_page(lk_page), .lk_hit(lk_hit),
        .lk_frame(lk_frame), .fill_en(fill_en), .fill_page(fill_page),
        .fill_frame(fill_frame), .flush_all(flush_all), .inv_en(inv_en),
        .inv_page(inv_page)
    );

    task automatic compare(input string tag);
        bit           eh = 0;
        logic [W-1:0] ef = '0;
        for (int i = 0; i < N; i++)
            if (m_v[i] && m_k[i] == lk_page) begin eh = 1; ef = m_f[i]; end
        total++;
        if (lk_hit !== eh || lk_frame !== ef) begin
            bad++;
            $display("FAIL %s page=%h actual hit=%0b frame=%h expected hit=%0b frame=%h",
                     tag, lk_page, lk_hit, lk_frame, eh, ef);
        end
    endtask

    task automatic model_update();
        int  li = -1;
        int  tg = -1;
        int  old;
        now++;
        for (int i = 0; i < N; i++) if (m_v[i] && m_k[i] == lk_page) li = i;
        if (flush_all) for (int i = 0; i < N; i++) m_v[i] = 0;
        if (inv_en) for (int i = 0; i < N; i++) if (m_v[i] && m_k[i] == inv_page) m_v[i] = 0;
        if (li >= 0 && !fill_en && !flush_all) m_t[li] = now;
        if (fill_en) begin
            for (int i = 0; i < N; i++) if (m_v[i] && m_k[i] == fill_page) tg = i;
            if (tg < 0) for (int i = N - 1; i >= 0; i--) if (!m_v[i]) tg = i;
            if (tg < 0) begin
                old = 32'h7fffffff;
                for (int i = 0; i < N; i++) if (m_t[i] < old) begin old = m_t[i]; tg = i; end
            end
            m_v[tg] = 1; m_k[tg] = fill_page; m_f[tg] = fill_frame; m_t[tg] = now;
        end
    endtask

    task automatic step(input bit fe, input logic [W-1:0] fp, input logic [W-1:0] ff,
                        input bit fl, input bit ie, input logic [W-1:0] ip,
                        input logic [W-1:0] lp, input string tag);
        @(negedge clk);
        fill_en = fe; fill_page = fp; fill_frame = ff;
        flush_all = fl; inv_en = ie; inv_page = ip; lk_page = lp;
        #1;
        compare(tag);
        model_update();
    endtask

    task automatic look(input logic [W-1:0] lp, input string tag);
        step(0, '0, '0, 0, 0, '0, lp, tag);
    endtask

    task automatic fill(input logic [W-1:0] fp, input logic [W-1:0] ff,
                        input logic [W-1:0] lp, input string tag);
        step(1, fp, ff, 0, 0, '0, lp, tag);
    endtask

    initial begin
        #(200000 * 4);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog expired");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [31:0] rs;
        for (int i = 0; i < N; i++) begin m_v[i] = 0; m_k[i] = '0; m_f[i] = '0; m_t[i] = 0; end
        repeat (2) @(posedge clk);
        @(negedge clk); lk_page = '0; #1; compare("R1 reset page0 miss");
        lk_page = 20'h00003; #1; compare("R1 reset other miss");
        @(negedge clk); rst_n = 1'b1;
        look(20'h0, "R1 after reset page0 miss");

        // R3 successive fills into empty slots; lookup in fill cycle still misses
        fill(20'h00003, 20'h00005, 20'h00003, "R3 fill0 same-cycle miss");
        fill(20'h00007, 20'h00009, 20'h00003, "R2 hit 3");
        fill(20'h00009, 20'h00001, 20'h00007, "R2 hit 7");
        fill(20'h0000B, 20'h00003, 20'h00009, "R2 hit 9");
        look(20'h0000B, "R3 hit B");
        look(20'h00000, "R1 page0 still miss");

        // R4 lookup hit refreshes 3, so 7 becomes least recent
        look(20'h00003, "R4 touch 3");
        fill(20'h0000D, 20'h0000A, 20'h0000D, "R4 fill D");
        look(20'h00007, "R4 7 evicted");
        look(20'h00003, "R4 3 kept");
        look(20'h0000D, "R4 D present");

        // R5 in-place update
        fill(20'h00009, 20'h00055, 20'h00009, "R5 update same-cycle old");
        look(20'h00009, "R5 new frame");
        look(20'h0000B, "R5 B kept");
        look(20'h00003, "R5 3 kept");

        // R7 single invalidate
        step(0, '0, '0, 0, 1, 20'h0000B, 20'h0000B, "R7 inv same-cycle still hit");
        look(20'h0000B, "R7 B gone");
        look(20'h0000D, "R7 D kept");
        step(0, '0, '0, 0, 1, 20'h12345, 20'h00009, "R7 inv nomatch");
        look(20'h00003, "R7 nomatch no effect");
        fill(20'h00021, 20'h00077, 20'h00021, "R3 hole refill");
        look(20'h00021, "R3 hole hit");
        look(20'h00009, "R3 9 kept");

        // R8 lookup during fill does not refresh
        look(20'h00009, "R8 prep");
        look(20'h00021, "R8 prep");
        look(20'h0000D, "R8 prep");
        fill(20'h0000D, 20'h000AA, 20'h00003, "R8 hit during fill");
        fill(20'h00030, 20'h00031, 20'h00003, "R8 evict");
        look(20'h00003, "R8 3 evicted");

        // R9 invalidate and fill together
        step(1, 20'h00040, 20'h00041, 0, 1, 20'h00021, 20'h00009, "R9 inv+fill");
        look(20'h00009, "R9 LRU not evicted");
        look(20'h00021, "R9 inv page gone");
        look(20'h00040, "R9 fill present");
        step(1, 20'h00040, 20'h00042, 0, 1, 20'h00040, 20'h00040, "R9 inv+refill same page");
        look(20'h00040, "R9 refilled");

        // R6 flush
        step(0, '0, '0, 1, 0, '0, 20'h0000D, "R6 flush same-cycle hit");
        look(20'h0000D, "R6 D gone");
        look(20'h00009, "R6 9 gone");
        step(1, 20'h00050, 20'h00051, 1, 0, '0, 20'h00040, "R6 flush+fill");
        look(20'h00050, "R6 fill survives");
        look(20'h00040, "R6 others gone");

        // mixed stress over a small page space
        rs = 32'h1234_5678;
        for (int c = 0; c < 3000; c++) begin
            rs = rs ^ (rs << 13); rs = rs ^ (rs >> 17); rs = rs ^ (rs << 5);
            step(rs[0], {17'h0, rs[3:1]}, {8'h0, rs[15:4]},
                 rs[20:16] == 5'd0, rs[23:21] == 3'd0, {17'h0, rs[26:24]},
                 {17'h0, rs[29:27]}, "R4 mixed");
        end

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule